// File: doc/BRIEF.md
# SRAM Controller with ECC Read-Modify-Write

This block sits between a bus master and an on-chip SRAM that holds 64-bit data words. Each word is stored as two protected halves, and each half carries seven check bits. The check bits form a single-error-correcting, double-error-detecting Hamming code over the 32 data bits of that half. The master issues reads and writes of 8, 16, 32 or 64 bits. It holds the request until `ready` is high; that cycle is the data phase. Every cycle before it in which `ready` is low counts as one wait state.

A 32-bit write goes straight into the addressed half. A 64-bit write is accepted at once. Its low half is stored in the accept cycle and its high half in the next cycle. An 8- or 16-bit write cannot produce valid check bits alone. The controller therefore reads the old half, corrects it, merges the new bytes, re-encodes the result and writes it back. Reads return the full corrected 64-bit word. Corrected single-bit errors and detected double-bit errors are signalled as one-cycle pulses together with `ready`.

For test, an XOR mask can be armed on an input. The controller applies it to the code bits of the next write and then disarms it.

Top module: `sram_ecc_ctrl`

## Requirements
- R1: A read (`we`=0) has exactly one wait state. In its data phase, `rdata` holds the whole 64-bit word at byte address `addr` (word index `addr[top:3]`), whatever `size` is.
- R2: A 32-bit write (`size`=2) has zero wait states. It replaces bytes 4*`addr[2]` to 4*`addr[2]`+3 of the word with `wdata[32*addr[2]+:32]` and leaves the other half unchanged.
- R3: A 64-bit write (`size`=3) has zero wait states and is stored as the low half, then the high half, on two consecutive cycles. A request presented in the cycle right after it gets one wait state.
- R4: An 8-bit (`size`=0) or 16-bit (`size`=1, `addr[0]`=0) write has exactly two wait states. It replaces only byte lanes `addr[2:0]` onward (1 or 2 lanes, taken from the same lanes of `wdata`), and all other bytes keep their value.
- R5: If exactly one bit of the 39-bit code word is flipped in either half, a read returns the original data, and `err_corr` is high in the data phase while `err_uncorr` is low.
- R6: If two bits of the same half's code word are flipped, a read raises `err_uncorr` in the data phase and keeps `err_corr` low. Both pulses are only ever high while `ready` is high.
- R7: A pulse on `inj_load` arms `inj_mask`. Bits 0 to 38 flip the low half's code word (bits 0 to 31 are data bits 0 to 31) and bits 38+1 to 77 flip the high half's code word. The mask is XORed into the code words stored by the next write access only, and writes after that are stored clean.
- R8: In an 8- or 16-bit write, a single-bit error in the old half is corrected before the merge. `err_corr` pulses in that write's data phase, and the rewritten half then reads back clean.
- R9: After reset, with no request, `ready`, `err_corr` and `err_uncorr` are low and no injection is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| addr | input | clog2(DEPTH)+3 | Byte address, aligned to the access size |
| wdata | input | 64 | Write data, lane-aligned |
| inj_load | input | 1 | Arms `inj_mask` for the next write |
| inj_mask | input | 78 | Code-bit flip mask, low half in bits 38:0 |
| ready | output | 1 | Data phase of the current access |
| rdata | output | 64 | Corrected read data |
| err_corr | output | 1 | Single-bit error corrected |
| err_uncorr | output | 1 | Double-bit error detected |

## Verification
Every word is first written with 64-bit writes. A long random mix of all four sizes at aligned offsets then runs against a byte-accurate reference memory, and the wait count of each access is compared with the count its size and its predecessor imply. This mix separates the lane-merge logic from the serialised high-half write. Each of the 78 code-bit positions is flipped one at a time, which shows that every data, check and parity bit is corrected, and a clean rewrite after each flip shows that the mask is spent. Random double flips in both halves show detection without a false correction. Directed cases inject a flip before a byte write to separate a correcting merge from a plain overwrite.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;
  localparam int HALF_W = 32;
  localparam int CHK_W  = 7;
  localparam int CODE_W = HALF_W + CHK_W;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WHI, S_MRG, S_RWR
  } ctrl_state_t;

  // Hamming position (1-based, skipping powers of two) of data bit j
  function automatic int data_pos(input int j);
    int n;
    int res;
    n   = -1;
    res = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        n++;
        if (n == j) res = p;
      end
    end
    return res;
  endfunction

  // code word: [38] overall parity, [37:32] Hamming checks, [31:0] data
  function automatic logic [CODE_W-1:0] ecc_encode(input logic [HALF_W-1:0] d);
    logic [5:0] c;
    int         pos;
    c = '0;
    for (int j = 0; j < HALF_W; j++) begin
      pos = data_pos(j);
      for (int i = 0; i < 6; i++)
        if (pos[i]) c[i] = c[i] ^ d[j];
    end
    return {(^d) ^ (^c), c, d};
  endfunction
endpackage

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 39
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [W-1:0]             wd,
  output logic [W-1:0]             rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      else    rd        <= mem[addr];
    end
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import sram_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [HALF_W-1:0] data,
  output logic              sgl,
  output logic              dbl
);
  logic [CODE_W-1:0] recode;
  logic [5:0]        syn;
  logic              par;
  logic              fixable;

  always_comb begin
    recode  = ecc_encode(code[HALF_W-1:0]);
    syn     = code[37:32] ^ recode[37:32];
    par     = ^code;
    fixable = par && (syn <= 6'd38);
    sgl     = fixable;
    dbl     = (!par && syn != 6'd0) || (par && syn > 6'd38);
    data    = code[HALF_W-1:0];
    for (int j = 0; j < HALF_W; j++)
      if (fixable && (int'(syn) == data_pos(j))) data[j] = ~code[j];
  end
endmodule

// File: rtl/sram_ecc_ctrl.sv
module sram_ecc_ctrl
  import sram_ecc_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [1:0]               size,
  input  logic [$clog2(DEPTH)+2:0] addr,
  input  logic [63:0]              wdata,
  input  logic                     inj_load,
  input  logic [2*CODE_W-1:0]      inj_mask,
  output logic                     ready,
  output logic [63:0]              rdata,
  output logic                     err_corr,
  output logic                     err_uncorr
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NBANK = 2;

  ctrl_state_t state_q, state_d;

  logic [IDX_W-1:0]  idx, idx_q, mem_addr;
  logic              half, half_q;
  logic [NBANK-1:0]  bank_en, bank_we, dec_sgl, dec_dbl;
  logic [CODE_W-1:0] bank_wd [NBANK];
  logic [CODE_W-1:0] bank_rd [NBANK];
  logic [CODE_W-1:0] enc_w   [NBANK];
  logic [CODE_W-1:0] mask_eff[NBANK];
  logic [HALF_W-1:0] dec_data[NBANK];

  logic [CODE_W-1:0] hw_q, mc_q;
  logic [HALF_W-1:0] nd_q, merged;
  logic [3:0]        be_q, be;
  logic              ce_q, ue_q;
  logic              ld_w64, ld_sub, ld_mrg, inj_use;
  logic              inj_armed_q, inj_armed_d;
  logic [2*CODE_W-1:0] inj_mask_q;

  assign idx  = addr[IDX_W+2:3];
  assign half = addr[2];
  assign be   = size[0] ? (4'b0011 << addr[1:0]) : (4'b0001 << addr[1:0]);

  for (genvar g = 0; g < NBANK; g++) begin : g_half
    assign enc_w[g]    = ecc_encode(wdata[HALF_W*g +: HALF_W]);
    assign mask_eff[g] = inj_armed_q ? inj_mask_q[CODE_W*g +: CODE_W] : '0;

    sram_bank #(.DEPTH(DEPTH), .W(CODE_W)) u_bank (
      .clk (clk),
      .en  (bank_en[g]),
      .we  (bank_we[g]),
      .addr(mem_addr),
      .wd  (bank_wd[g]),
      .rd  (bank_rd[g])
    );

    secded_dec u_dec (
      .code(bank_rd[g]),
      .data(dec_data[g]),
      .sgl (dec_sgl[g]),
      .dbl (dec_dbl[g])
    );
  end

  // next-state and array control
  always_comb begin
    state_d  = state_q;
    bank_en  = '0;
    bank_we  = '0;
    mem_addr = idx;
    ld_w64   = 1'b0;
    ld_sub   = 1'b0;
    ld_mrg   = 1'b0;
    inj_use  = 1'b0;
    for (int g = 0; g < NBANK; g++) bank_wd[g] = enc_w[g] ^ mask_eff[g];
    unique case (state_q)
      S_IDLE: if (req) begin
        if (!we) begin
          bank_en = '1;
          state_d = S_RD;
        end else if (size == 2'd2) begin
          bank_en[half] = 1'b1;
          bank_we[half] = 1'b1;
          inj_use       = 1'b1;
        end else if (size == 2'd3) begin
          bank_en[0] = 1'b1;
          bank_we[0] = 1'b1;
          inj_use    = 1'b1;
          ld_w64     = 1'b1;
          state_d    = S_WHI;
        end else begin
          bank_en = '1;
          ld_sub  = 1'b1;
          state_d = S_MRG;
        end
      end
      S_RD:  state_d = S_IDLE;
      S_WHI: begin
        mem_addr   = idx_q;
        bank_en[1] = 1'b1;
        bank_we[1] = 1'b1;
        bank_wd[1] = hw_q;
        state_d    = S_IDLE;
      end
      S_MRG: begin
        ld_mrg  = 1'b1;
        state_d = S_RWR;
      end
      S_RWR: begin
        mem_addr        = idx_q;
        bank_en[half_q] = 1'b1;
        bank_we[half_q] = 1'b1;
        for (int g = 0; g < NBANK; g++) bank_wd[g] = mc_q ^ mask_eff[g];
        inj_use         = 1'b1;
        state_d         = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    merged = dec_data[half_q];
    for (int b = 0; b < 4; b++)
      if (be_q[b]) merged[8*b +: 8] = nd_q[8*b +: 8];
  end

  always_comb begin
    inj_armed_d = inj_armed_q;
    if (inj_load)     inj_armed_d = 1'b1;
    else if (inj_use) inj_armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      inj_armed_q <= 1'b0;
      ce_q        <= 1'b0;
      ue_q        <= 1'b0;
    end else begin
      state_q     <= state_d;
      inj_armed_q <= inj_armed_d;
      if (ld_mrg) begin
        ce_q <= dec_sgl[half_q] && !dec_dbl[half_q];
        ue_q <= dec_dbl[half_q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (inj_load) inj_mask_q <= inj_mask;
    if (ld_w64) begin
      hw_q  <= enc_w[1] ^ mask_eff[1];
      idx_q <= idx;
    end
    if (ld_sub) begin
      idx_q  <= idx;
      half_q <= half;
      be_q   <= be;
      nd_q   <= wdata[HALF_W*half +: HALF_W];
    end
    if (ld_mrg) mc_q <= ecc_encode(merged);
  end

  assign ready = (state_q == S_IDLE && req && we && size[1]) ||
                 state_q == S_RD || state_q == S_RWR;
  assign rdata = {dec_data[1], dec_data[0]};
  assign err_corr   = (state_q == S_RD && (|dec_sgl) && !(|dec_dbl)) ||
                      (state_q == S_RWR && ce_q);
  assign err_uncorr = (state_q == S_RD && (|dec_dbl)) ||
                      (state_q == S_RWR && ue_q);

  AST_RD_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req && !we) |=> ready); // R1
  AST_W32_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req && we && size == 2'd2) |-> ($countones(bank_we) == 1 && ready)); // R2
  AST_W64_HI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req && we && size == 2'd3) |=> (bank_we == 2'b10 && !ready)); // R3
  AST_SUB_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req && we && !size[1]) |=> !ready); // R4
  AST_SUB_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state_q == S_IDLE && req && we && !size[1], 2) |-> (ready && bank_we != 2'b00)); // R4
  AST_ERR_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr || err_uncorr) |-> ready); // R5
  AST_UE_NOT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    err_uncorr |-> !err_corr); // R6
  AST_INJ_ONE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_armed_q && inj_use && !inj_load) |=> !inj_armed_q); // R7
endmodule

// File: tb/sim_sram_ecc_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ecc_ctrl;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH) + 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, inj_load;
  logic [1:0]  size;
  logic [AW-1:0] addr;
  logic [63:0] wdata, rdata;
  logic [77:0] inj_mask;
  logic        ready, err_corr, err_uncorr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  prev_w64 = 0;
  logic [63:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  sram_ecc_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .inj_load(inj_load), .inj_mask(inj_mask), .ready(ready),
    .rdata(rdata), .err_corr(err_corr), .err_uncorr(err_uncorr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int base_wait(input bit w, input logic [1:0] sz);
    if (!w) return 1;
    if (sz[1]) return 0;
    return 2;
  endfunction

  function automatic logic [63:0] apply_wr(input logic [63:0] old, input logic [1:0] sz,
                                           input logic [2:0] off, input logic [63:0] d);
    logic [63:0] r;
    r = old;
    for (int b = 0; b < (1 << sz); b++) r[8*(off+b) +: 8] = d[8*(off+b) +: 8];
    return r;
  endfunction

  task automatic op(input bit w, input logic [1:0] sz, input logic [AW-1:0] a, input logic [63:0] d,
                    input bit ece, input bit eue, input bit cd, input string tag);
    int wt;
    int ew;
    logic [63:0] rd;
    logic c, u;
    @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d; wt = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; wt++;
    end
    rd = rdata; c = err_corr; u = err_uncorr;
    @(posedge clk);
    ew = base_wait(w, sz) + (prev_w64 ? 1 : 0);
    chk(wt == ew, {tag, " wait states"}, 64'(wt), 64'(ew));
    chk(c == ece, {tag, " err_corr"}, 64'(c), 64'(ece));
    chk(u == eue, {tag, " err_uncorr"}, 64'(u), 64'(eue));
    if (w) ref_mem[a[AW-1:3]] = apply_wr(ref_mem[a[AW-1:3]], sz, a[2:0], d);
    else if (cd) chk(rd == ref_mem[a[AW-1:3]], {tag, " read data"}, rd, ref_mem[a[AW-1:3]]);
    prev_w64 = w && sz == 2'd3;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0;
    @(posedge clk);
    prev_w64 = 0;
  endtask

  task automatic inject(input logic [77:0] m);
    @(negedge clk);
    req = 1'b0; inj_load = 1'b1; inj_mask = m;
    @(negedge clk);
    inj_load = 1'b0;
    prev_w64 = 0;
  endtask

  function automatic logic [AW-1:0] rnd_addr(input logic [1:0] sz);
    logic [2:0] off;
    off = 3'($urandom_range(0, 7));
    case (sz)
      2'd1: off[0] = 1'b0;
      2'd2: off[1:0] = 2'b00;
      2'd3: off = 3'b000;
      default: ;
    endcase
    return {($clog2(DEPTH))'($urandom_range(0, DEPTH - 1)), off};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 64'd1, 64'd0);
    finish_up();
  end

  initial begin
    logic [63:0] d;
    logic [1:0] sz;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req = 1'b0; we = 1'b0; size = 2'd0; addr = '0; wdata = '0;
    inj_load = 1'b0; inj_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!ready, "R9 ready after reset", 64'(ready), 64'd0);
    chk(!err_corr && !err_uncorr, "R9 error pulses after reset",
        {62'd0, err_corr, err_uncorr}, 64'd0);

    // R3: fill every word with back-to-back 64-bit writes
    for (int i = 0; i < DEPTH; i++)
      op(1, 2'd3, AW'(i << 3), {$urandom, $urandom}, 0, 0, 0, "R3 fill");
    // R1: read all words back
    for (int i = 0; i < DEPTH; i++)
      op(0, 2'd0, AW'(i << 3), '0, 0, 0, 1, "R1 read");

    // R9: nothing armed after reset, so a write followed by a read is clean
    op(1, 2'd3, AW'(5 << 3), 64'h0123_4567_89ab_cdef, 0, 0, 0, "R9 clean write");
    op(0, 2'd0, AW'(5 << 3), '0, 0, 0, 1, "R9 no injection armed");

    // R2 directed: 32-bit write to high half leaves low half
    op(1, 2'd2, AW'((7 << 3) | 4), 64'hdead_beef_0000_0000, 0, 0, 0, "R2 w32 high");
    op(0, 2'd2, AW'(7 << 3), '0, 0, 0, 1, "R2 read after w32");
    // R4 directed: 16-bit write at lanes 6..7, byte write at lane 0
    op(1, 2'd1, AW'((7 << 3) | 6), 64'h5a5a_0000_0000_0000, 0, 0, 0, "R4 w16 lanes 6-7");
    op(1, 2'd0, AW'(7 << 3), 64'h0000_0000_0000_00c3, 0, 0, 0, "R4 w8 lane 0");
    op(0, 2'd0, AW'(7 << 3), '0, 0, 0, 1, "R4 read after sub-word");

    // random mix, all sizes; R1 R2 R3 R4
    for (int i = 0; i < 600; i++) begin
      sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0)
        op(0, sz, rnd_addr(sz), '0, 0, 0, 1, "R1 random read");
      else
        op(1, sz, rnd_addr(sz), {$urandom, $urandom}, 0, 0, 0, "R4 random write");
    end

    // R5 R7: every single code-bit position
    for (int k = 0; k < 78; k++) begin
      d = {$urandom, $urandom};
      inject(78'(1) << k);
      op(1, 2'd3, AW'(k % DEPTH) << 3, d, 0, 0, 0, "R7 injected write");
      op(0, 2'd0, AW'(k % DEPTH) << 3, '0, 1, 0, 1, "R5 single flip corrected");
      op(1, 2'd3, AW'(k % DEPTH) << 3, ~d, 0, 0, 0, "R7 next write");
      op(0, 2'd0, AW'(k % DEPTH) << 3, '0, 0, 0, 1, "R7 mask spent");
    end

    // R6: double flips within one half
    for (int t = 0; t < 40; t++) begin
      int h, i1, i2;
      h  = t % 2;
      i1 = $urandom_range(0, 38);
      i2 = (i1 + $urandom_range(1, 38)) % 39;
      inject((78'(1) << (39*h + i1)) | (78'(1) << (39*h + i2)));
      op(1, 2'd3, AW'(t % DEPTH) << 3, {$urandom, $urandom}, 0, 0, 0, "R6 injected write");
      op(0, 2'd0, AW'(t % DEPTH) << 3, '0, 0, 1, 0, "R6 double flip detected");
      op(1, 2'd3, AW'(t % DEPTH) << 3, {$urandom, $urandom}, 0, 0, 0, "R6 rewrite");
    end

    // R8: correction before merge, low and high halves
    inject(78'(1) << 9);
    op(1, 2'd3, AW'(3 << 3), 64'h1111_2222_3333_4444, 0, 0, 0, "R8 injected write");
    op(1, 2'd0, AW'((3 << 3) | 1), 64'h0000_0000_0000_7700, 1, 0, 0, "R8 rmw corrects");
    op(0, 2'd0, AW'(3 << 3), '0, 0, 0, 1, "R8 merged word clean");
    inject(78'(1) << (39 + 20));
    op(1, 2'd3, AW'(4 << 3), 64'h8888_7777_6666_5555, 0, 0, 0, "R8 injected write hi");
    op(1, 2'd1, AW'((4 << 3) | 4), 64'h0000_abcd_0000_0000, 1, 0, 0, "R8 rmw corrects hi");
    op(0, 2'd0, AW'(4 << 3), '0, 0, 0, 1, "R8 merged hi clean");

    idle();
    @(negedge clk); #1;
    chk(!ready, "R9 ready idle", 64'(ready), 64'd0);
    finish_up();
  end
endmodule